// File: doc/BRIEF.md
# AHB to APB Transfer Bridge

This block sits on a high-performance AHB bus as a slave and converts every selected AHB read or write into exactly one APB transfer on a peripheral bus that runs on the same clock. It captures the address-phase controls when a valid transfer is presented, samples the write data one cycle later, and then runs the APB setup and access phases. While the peripheral side is busy, the AHB side is held in wait states.

When the peripheral signals completion, the bridge returns the registered read data with an OKAY response. If the peripheral reports a slave error, the bridge returns an ERROR response spread over two cycles. The bridge also generates per-byte write strobes from the transfer size and the low address bits. It maps the AHB protection bits onto the three APB protection bits, with the security bit coming from a parameter.

Top module: `periph_bus_bridge`

## Requirements
- R1: A transfer is accepted only in a cycle where ahbSel, ahbReadyIn and ahbReadyOut are high and ahbTrans is NONSEQ (2'b10) or SEQ (2'b11). IDLE (2'b00), BUSY (2'b01), a low select or a low ahbReadyIn starts no APB transfer.
- R2: Two cycles after the accepting edge, apbSel rises with apbEnable low for exactly one cycle. apbEnable is then high, with apbSel, until the cycle after the peripheral asserts apbReady. After that cycle both drop.
- R3: ahbReadyOut is low from the cycle after acceptance until the transfer completes, including every peripheral wait cycle.
- R4: apbAddr and apbWrite carry the captured address and direction and stay stable for the whole APB transfer (apbWrite high = write).
- R5: Write data is sampled from ahbWdata in the cycle after the address phase and is driven on apbWdata during setup and access.
- R6: apbStrb has one bit per data byte. A read gives all zeros. On a 32-bit bus a byte write (size 0) sets bit ahbAddr[1:0], a halfword (size 1) sets 4'b0011 or 4'b1100 by ahbAddr[1], and a word (size 2) sets 4'b1111.
- R7: apbProt[0] equals ahbProt[1] (privileged), apbProt[1] equals the NON_SECURE parameter (default 1), and apbProt[2] equals the inverse of ahbProt[0] (instruction when ahbProt[0] is low).
- R8: In the cycle after apbEnable and apbReady are both high with apbSlvErr low, ahbReadyOut is high, ahbResp is low (OKAY), and ahbRdata holds the apbRdata sampled at completion.
- R9: In the cycle after a completion with apbSlvErr high, ahbResp is high with ahbReadyOut low. In the next cycle ahbResp stays high with ahbReadyOut high. In the cycle after that, ahbResp is low again.
- R10: After reset, ahbReadyOut is high, ahbResp is low, apbSel and apbEnable are low, and ahbRdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ahbSel | input | 1 | Slave select from the AHB decoder |
| ahbAddr | input | ADDR_W | AHB address |
| ahbTrans | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| ahbWrite | input | 1 | High for write, low for read |
| ahbSize | input | 3 | Transfer size as log2 of bytes |
| ahbProt | input | 2 | Bit 0 data/instruction, bit 1 privileged |
| ahbWdata | input | DATA_W | Write data, valid in the data phase |
| ahbReadyIn | input | 1 | Bus-wide ready: previous transfer done |
| ahbReadyOut | output | 1 | This slave's ready, low to insert waits |
| ahbResp | output | 1 | Low OKAY, high ERROR |
| ahbRdata | output | DATA_W | Read data returned to the AHB master |
| apbAddr | output | ADDR_W | Peripheral address |
| apbSel | output | 1 | Peripheral select |
| apbEnable | output | 1 | High in the access phase |
| apbWrite | output | 1 | Peripheral transfer direction |
| apbWdata | output | DATA_W | Peripheral write data |
| apbStrb | output | DATA_W/8 | Byte-lane write strobes |
| apbProt | output | 3 | Privileged, non-secure, instruction |
| apbRdata | input | DATA_W | Peripheral read data |
| apbReady | input | 1 | Peripheral completes the access phase |
| apbSlvErr | input | 1 | Peripheral error, sampled with apbReady |

## Verification
The assertions assume that the peripheral asserts apbReady only while apbSel and apbEnable are high, and that apbSlvErr matters only together with apbReady. They also assume that ahbReadyIn reflects this slave's own ready output whenever it is the selected slave. The stimulus keeps to these assumptions in three ways. It drives apbReady for exactly one access-phase cycle and ties ahbReadyIn to ahbReadyOut, except during one directed case that forces it low. It issues only addresses aligned to the transfer size, with sizes no wider than the bus.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } ahbTrans_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_ACCESS,
    ST_ERR1,
    ST_ERR2
  } bridgeState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic loadWdata;
    logic loadRdata;
  } dpStrobe_t;

endpackage

// File: rtl/bridge_ctrl.sv
`timescale 1ns/1ps
module bridge_ctrl
  import bridge_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ahbSel,
  input  logic      ahbReadyIn,
  input  logic [1:0] ahbTrans,
  input  logic      apbReady,
  input  logic      apbSlvErr,
  output dpStrobe_t strobes,
  output logic      apbSel,
  output logic      apbEnable,
  output logic      ahbReadyOut,
  output logic      ahbResp
);

  bridgeState_t state, stateNext;
  logic validTrans;
  logic accept;

  always_comb begin
    validTrans = (ahbTrans == TR_NONSEQ) || (ahbTrans == TR_SEQ);
    accept = ahbSel && ahbReadyIn && validTrans &&
             ((state == ST_IDLE) || (state == ST_ERR2));
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_ERR2: stateNext = accept ? ST_LOAD : ST_IDLE;
      ST_LOAD:          stateNext = ST_SETUP;
      ST_SETUP:         stateNext = ST_ACCESS;
      ST_ACCESS: begin
        if (apbReady) stateNext = apbSlvErr ? ST_ERR1 : ST_IDLE;
      end
      ST_ERR1:          stateNext = ST_ERR2;
      default:          stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    apbSel      = (state == ST_SETUP) || (state == ST_ACCESS);
    apbEnable   = (state == ST_ACCESS);
    ahbReadyOut = (state == ST_IDLE) || (state == ST_ERR2);
    ahbResp     = (state == ST_ERR1) || (state == ST_ERR2);
    strobes.capture   = accept;
    strobes.loadWdata = (state == ST_LOAD);
    strobes.loadRdata = (state == ST_ACCESS) && apbReady;
  end

endmodule

// File: rtl/bridge_dpath.sv
`timescale 1ns/1ps
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter bit NON_SECURE = 1'b1,
  localparam int STRB_W    = DATA_W / 8,
  localparam int OFF_W     = (STRB_W > 1) ? $clog2(STRB_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [ADDR_W-1:0] ahbAddr,
  input  logic              ahbWrite,
  input  logic [2:0]        ahbSize,
  input  logic [1:0]        ahbProt,
  input  logic [DATA_W-1:0] ahbWdata,
  input  logic [DATA_W-1:0] apbRdata,
  output logic [ADDR_W-1:0] apbAddr,
  output logic              apbWrite,
  output logic [DATA_W-1:0] apbWdata,
  output logic [STRB_W-1:0] apbStrb,
  output logic [2:0]        apbProt,
  output logic [DATA_W-1:0] ahbRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [2:0]        sizeQ;
  logic [1:0]        protQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      sizeQ  <= '0;
      protQ  <= '0;
    end else if (strobes.capture) begin
      addrQ  <= ahbAddr;
      writeQ <= ahbWrite;
      sizeQ  <= ahbSize;
      protQ  <= ahbProt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  wdataQ <= '0;
    else if (strobes.loadWdata) wdataQ <= ahbWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rdataQ <= '0;
    else if (strobes.loadRdata) rdataQ <= apbRdata;
  end

  // Byte lanes: a run of 2**size lanes starting at the size-aligned offset
  always_comb begin
    int laneCount;
    int laneBase;
    laneCount = 1 << sizeQ;
    if (laneCount > STRB_W) laneCount = STRB_W;
    laneBase = int'(addrQ[OFF_W-1:0]) & ~(laneCount - 1);
    for (int i = 0; i < STRB_W; i++) begin
      apbStrb[i] = writeQ && (i >= laneBase) && (i < laneBase + laneCount);
    end
  end

  assign apbProt  = {~protQ[0], NON_SECURE, protQ[1]};
  assign apbAddr  = addrQ;
  assign apbWrite = writeQ;
  assign apbWdata = wdataQ;
  assign ahbRdata = rdataQ;

endmodule

// File: rtl/periph_bus_bridge.sv
`timescale 1ns/1ps
module periph_bus_bridge
  import bridge_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter bit NON_SECURE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ahbSel,
  input  logic [ADDR_W-1:0]     ahbAddr,
  input  logic [1:0]            ahbTrans,
  input  logic                  ahbWrite,
  input  logic [2:0]            ahbSize,
  input  logic [1:0]            ahbProt,
  input  logic [DATA_W-1:0]     ahbWdata,
  input  logic                  ahbReadyIn,
  output logic                  ahbReadyOut,
  output logic                  ahbResp,
  output logic [DATA_W-1:0]     ahbRdata,
  output logic [ADDR_W-1:0]     apbAddr,
  output logic                  apbSel,
  output logic                  apbEnable,
  output logic                  apbWrite,
  output logic [DATA_W-1:0]     apbWdata,
  output logic [DATA_W/8-1:0]   apbStrb,
  output logic [2:0]            apbProt,
  input  logic [DATA_W-1:0]     apbRdata,
  input  logic                  apbReady,
  input  logic                  apbSlvErr
);

  dpStrobe_t strobes;

  bridge_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ahbSel      (ahbSel),
    .ahbReadyIn  (ahbReadyIn),
    .ahbTrans    (ahbTrans),
    .apbReady    (apbReady),
    .apbSlvErr   (apbSlvErr),
    .strobes     (strobes),
    .apbSel      (apbSel),
    .apbEnable   (apbEnable),
    .ahbReadyOut (ahbReadyOut),
    .ahbResp     (ahbResp)
  );

  bridge_dpath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NON_SECURE (NON_SECURE)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .ahbAddr  (ahbAddr),
    .ahbWrite (ahbWrite),
    .ahbSize  (ahbSize),
    .ahbProt  (ahbProt),
    .ahbWdata (ahbWdata),
    .apbRdata (apbRdata),
    .apbAddr  (apbAddr),
    .apbWrite (apbWrite),
    .apbWdata (apbWdata),
    .apbStrb  (apbStrb),
    .apbProt  (apbProt),
    .ahbRdata (ahbRdata)
  );

endmodule

// File: rtl/bridge_chk.sv
`timescale 1ns/1ps
module bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                ahbReadyOut,
  input logic                ahbResp,
  input logic                apbSel,
  input logic                apbEnable,
  input logic                apbReady,
  input logic                apbSlvErr,
  input logic                apbWrite,
  input logic [ADDR_W-1:0]   apbAddr,
  input logic [DATA_W/8-1:0] apbStrb
);

  // Access phase never shows up without select
  assert_enable_needs_sel_R2: assert property (@(posedge clk) disable iff (!rstN)
    apbEnable |-> apbSel);

  // First select cycle is the setup phase
  assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(apbSel) |-> !apbEnable);

  assert_setup_to_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && !apbEnable) |=> (apbSel && apbEnable));

  // AHB side waits while the peripheral transfer is open
  assert_wait_during_xfer_R3: assert property (@(posedge clk) disable iff (!rstN)
    apbSel |-> !ahbReadyOut);

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && !(apbEnable && apbReady)) |=> (apbSel && $stable(apbAddr) && $stable(apbWrite)));

  assert_read_no_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (apbSel && !apbWrite) |-> (apbStrb == '0));

  assert_okay_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    (apbEnable && apbReady && !apbSlvErr) |=> (ahbReadyOut && !ahbResp && !apbSel));

  assert_err_first_R9: assert property (@(posedge clk) disable iff (!rstN)
    (apbEnable && apbReady && apbSlvErr) |=> (ahbResp && !ahbReadyOut));

  assert_err_second_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ahbResp && !ahbReadyOut) |=> (ahbResp && ahbReadyOut));

endmodule

bind periph_bus_bridge bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .ahbReadyOut (ahbReadyOut),
  .ahbResp     (ahbResp),
  .apbSel      (apbSel),
  .apbEnable   (apbEnable),
  .apbReady    (apbReady),
  .apbSlvErr   (apbSlvErr),
  .apbWrite    (apbWrite),
  .apbAddr     (apbAddr),
  .apbStrb     (apbStrb)
);

// File: tb/sim_periph_bus_bridge.sv
`timescale 1ns/1ps
module sim_periph_bus_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ahbSel = 1'b0;
  logic [31:0] ahbAddr = '0;
  logic [1:0]  ahbTrans = 2'b00;
  logic        ahbWrite = 1'b0;
  logic [2:0]  ahbSize = '0;
  logic [1:0]  ahbProt = '0;
  logic [31:0] ahbWdata = '0;
  logic        forceLow = 1'b0;
  logic        ahbReadyIn;
  logic        ahbReadyOut;
  logic        ahbResp;
  logic [31:0] ahbRdata;
  logic [31:0] apbAddr;
  logic        apbSel;
  logic        apbEnable;
  logic        apbWrite;
  logic [31:0] apbWdata;
  logic [3:0]  apbStrb;
  logic [2:0]  apbProt;
  logic [31:0] apbRdata = '0;
  logic        apbReady = 1'b0;
  logic        apbSlvErr = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign ahbReadyIn = forceLow ? 1'b0 : ahbReadyOut;

  periph_bus_bridge u0 (
    .clk(clk), .rstN(rstN), .ahbSel(ahbSel), .ahbAddr(ahbAddr),
    .ahbTrans(ahbTrans), .ahbWrite(ahbWrite), .ahbSize(ahbSize),
    .ahbProt(ahbProt), .ahbWdata(ahbWdata), .ahbReadyIn(ahbReadyIn),
    .ahbReadyOut(ahbReadyOut), .ahbResp(ahbResp), .ahbRdata(ahbRdata),
    .apbAddr(apbAddr), .apbSel(apbSel), .apbEnable(apbEnable),
    .apbWrite(apbWrite), .apbWdata(apbWdata), .apbStrb(apbStrb),
    .apbProt(apbProt), .apbRdata(apbRdata), .apbReady(apbReady),
    .apbSlvErr(apbSlvErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expStrb(input logic [2:0] sz, input logic [1:0] a, input logic w);
    if (!w) return 4'b0000;
    case (sz)
      3'd0:    return 4'b0001 << a;
      3'd1:    return a[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [2:0] expProt(input logic [1:0] p);
    return {~p[0], 1'b1, p[1]};
  endfunction

  // One complete bridged transfer; entered and left at a falling edge
  task automatic xfer(input logic [31:0] a, input logic w, input logic [2:0] sz,
                      input logic [1:0] pr, input logic seq, input logic [31:0] wd,
                      input int waits, input logic err, input logic [31:0] rd);
    ahbSel = 1'b1; ahbTrans = seq ? 2'b11 : 2'b10; ahbAddr = a;
    ahbWrite = w; ahbSize = sz; ahbProt = pr;
    @(negedge clk);
    ahbSel = 1'b0; ahbTrans = 2'b00; ahbAddr = ~a; ahbWdata = wd;
    chk("R3 wait after accept", {31'b0, ahbReadyOut}, 32'd0);
    chk("R2 no select yet", {31'b0, apbSel}, 32'd0);
    @(negedge clk);
    ahbWdata = ~wd;
    chk("R2 setup select", {31'b0, apbSel}, 32'd1);
    chk("R2 setup enable low", {31'b0, apbEnable}, 32'd0);
    chk("R4 address", apbAddr, a);
    chk("R4 direction", {31'b0, apbWrite}, {31'b0, w});
    if (w) chk("R5 write data", apbWdata, wd);
    chk("R6 strobe", {28'b0, apbStrb}, {28'b0, expStrb(sz, a[1:0], w)});
    chk("R7 protection", {29'b0, apbProt}, {29'b0, expProt(pr)});
    @(negedge clk);
    chk("R2 access enable", {31'b0, apbEnable}, 32'd1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R3 held during wait", {31'b0, ahbReadyOut}, 32'd0);
      chk("R2 enable held", {30'b0, apbSel, apbEnable}, 32'd3);
      chk("R4 address held", apbAddr, a);
    end
    apbReady = 1'b1; apbSlvErr = err; apbRdata = rd;
    @(negedge clk);
    apbReady = 1'b0; apbSlvErr = 1'b0; apbRdata = $urandom;
    chk("R2 select released", {30'b0, apbSel, apbEnable}, 32'd0);
    if (err) begin
      chk("R9 error first cycle", {30'b0, ahbResp, ahbReadyOut}, 32'd2);
      @(negedge clk);
      chk("R9 error second cycle", {30'b0, ahbResp, ahbReadyOut}, 32'd3);
      @(negedge clk);
      chk("R9 error cleared", {30'b0, ahbResp, ahbReadyOut}, 32'd1);
    end else begin
      chk("R8 okay completion", {30'b0, ahbResp, ahbReadyOut}, 32'd1);
      if (!w) chk("R8 read data", ahbRdata, rd);
    end
  endtask

  // Present a transfer that must not be accepted; check no APB activity
  task automatic noXfer(input logic sel, input logic [1:0] tr, input logic lowReady, input string tag);
    ahbSel = sel; ahbTrans = tr; ahbAddr = 32'h0000_0040; ahbWrite = 1'b1; forceLow = lowReady;
    @(negedge clk);
    ahbSel = 1'b0; ahbTrans = 2'b00; forceLow = 1'b0;
    chk({"R1 ", tag, " ready"}, {31'b0, ahbReadyOut}, 32'd1);
    @(negedge clk);
    @(negedge clk);
    chk({"R1 ", tag, " no select"}, {31'b0, apbSel}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    #1;
    chk("R10 reset ready", {31'b0, ahbReadyOut}, 32'd1);
    chk("R10 reset resp", {31'b0, ahbResp}, 32'd0);
    chk("R10 reset select", {30'b0, apbSel, apbEnable}, 32'd0);
    chk("R10 reset rdata", ahbRdata, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    noXfer(1'b1, 2'b00, 1'b0, "idle");
    noXfer(1'b1, 2'b01, 1'b0, "busy");
    noXfer(1'b0, 2'b10, 1'b0, "unselected");
    noXfer(1'b1, 2'b10, 1'b1, "ready low");

    for (int l = 0; l < 4; l++)
      xfer(32'h1000_0000 + l, 1'b1, 3'd0, 2'(l), 1'b0, 32'hA5A5_0000 + l, 0, 1'b0, 32'h0);
    xfer(32'h1000_0002, 1'b1, 3'd1, 2'b10, 1'b1, 32'h1111_2222, 1, 1'b0, 32'h0);
    xfer(32'h1000_0000, 1'b1, 3'd1, 2'b01, 1'b0, 32'h3333_4444, 0, 1'b0, 32'h0);
    xfer(32'h2000_0004, 1'b1, 3'd2, 2'b11, 1'b0, 32'hDEAD_BEEF, 3, 1'b0, 32'h0);
    xfer(32'h2000_0008, 1'b0, 3'd2, 2'b00, 1'b0, 32'h0, 2, 1'b0, 32'hCAFE_F00D);
    xfer(32'h2000_000C, 1'b0, 3'd0, 2'b10, 1'b1, 32'h0, 0, 1'b1, 32'h0BAD_0BAD);
    xfer(32'h2000_0010, 1'b1, 3'd2, 2'b01, 1'b0, 32'h5555_AAAA, 1, 1'b1, 32'h0);
    xfer(32'h2000_0014, 1'b0, 3'd2, 2'b11, 1'b0, 32'h0, 0, 1'b0, 32'h7777_8888);

    for (int n = 0; n < 80; n++) begin
      logic [2:0] sz;
      logic [31:0] a;
      sz = 3'($urandom_range(0, 2));
      a = $urandom & ~((32'd1 << sz) - 32'd1);
      xfer(a, 1'($urandom), sz, 2'($urandom), 1'($urandom), $urandom,
           int'($urandom_range(0, 3)), ($urandom_range(0, 3) == 0), $urandom);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule